// File: doc/BRIEF.md
# USB Host Port Status and Control Register

This block holds the per-port control word of a USB 2.0 host controller. Software reads and writes a 32-bit word through a simple register strobe. Only a handful of its fields are built here: an enable that turns a device connect into a power-management wake event, a four-bit test mode selector, a port ownership bit that hands the port to a companion full/low-speed controller, and a power indication that is fixed on. Every other bit position reads as zero and ignores writes.

The block watches three controller-level signals. A rising connect status raises a one-clock request to set the power-management status bit, but only when the wake enable is set. The configure flag drives port ownership: the port belongs to the companion controller while the flag is low, and it is taken back whenever the flag rises. The run/stop bit blocks any change of test mode while the controller is running. The selected test mode is presented to the PHY side. A separate flag tells the PHY to turn off pre-emphasis during the two static line-state tests.

Top module: `usb_port_ctl_reg`

## Requirements
- R1: After reset the read word is 0x00003000, `pme_set` is 0, `test_mode` is 0 and `preemph_off` is 0. `companion_own` is 1 while `cfg_flag` is 0.
- R2: Bit 20 is a read/write wake enable. While it is 1, a 0-to-1 change of `conn_sts` makes `pme_set` high for exactly one clock.
- R3: `pme_set` stays 0 when the wake enable is 0, when `conn_sts` falls, and while `conn_sts` holds steady.
- R4: Bits 19:16 select the test mode and are read back there. A write takes effect on the next clock. Code 0 is normal operation, 1 is J state, 2 is K state, 3 is SE0/NAK, 4 is packet and 5 is force enable. `test_mode` shows the stored code.
- R5: `preemph_off` is 1 exactly when the stored code is 1 or 2.
- R6: A write whose bits 19:16 hold a reserved code (6 to 15) leaves the stored test code unchanged.
- R7: A write made while `run_stop` is 1 leaves the stored test code unchanged.
- R8: Bits 31:21, 15:14 and 11:0 always read 0, and bit 12 always reads 1, whatever has been written.
- R9: Bit 13 is the port owner, and `companion_own` mirrors it. The clock after any cycle with `cfg_flag` 0 finds it at 1. While `cfg_flag` stays 1, a write sets it from write bit 13.
- R10: In the clock after `cfg_flag` rises from 0 to 1, bit 13 is 0, even if a write of 1 to bit 13 came in the same cycle as the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register word |
| conn_sts | input | 1 | Current connect status of the port |
| cfg_flag | input | 1 | Controller-wide configure flag |
| run_stop | input | 1 | Controller run/stop bit |
| pme_set | output | 1 | One-clock request to set the power-management status bit |
| test_mode | output | 4 | Active test mode code |
| preemph_off | output | 1 | Forces pre-emphasis off during J/K tests |
| companion_own | output | 1 | 1 when the companion controller owns the port |

## Verification
On every clock, the assertions check that the wake pulse never lasts two cycles and that the stored test code never holds a reserved value. They also check that the code does not move during a cycle in which the controller is running, that a low configure flag leaves the port with the companion, and that a rising flag takes it back. Only the bench scenarios can show that the right code is stored and read from the right bit positions. The same goes for the pulse appearing at all and for a reserved or blocked write keeping the earlier code. The scenarios also cover the race between a write to the owner bit and a configure-flag edge in the same cycle, and the fixed bits reading back unchanged after a write of all ones.

// File: rtl/usbp_pkg.sv
package usbp_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned TM_W       = 4;
  localparam int unsigned WAKE_BIT   = 20;
  localparam int unsigned TM_LSB     = 16;
  localparam int unsigned TM_MSB     = TM_LSB + TM_W - 1;
  localparam int unsigned OWNER_BIT  = 13;
  localparam int unsigned POWER_BIT  = 12;

  typedef enum logic [TM_W-1:0] {
    TM_OFF    = 4'd0,
    TM_JSTATE = 4'd1,
    TM_KSTATE = 4'd2,
    TM_SE0NAK = 4'd3,
    TM_PACKET = 4'd4,
    TM_FORCE  = 4'd5
  } test_code_e;

  localparam logic [TM_W-1:0] TM_LAST_LEGAL = TM_FORCE;
endpackage

// File: rtl/port_edge_det.sv
module port_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = sig_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/port_test_sel.sv
module port_test_sel
  import usbp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [TM_W-1:0] wr_code,
  input  logic            run_stop,
  output logic [TM_W-1:0] code,
  output logic            preemph_off
);
  logic [TM_W-1:0] code_q;
  logic [TM_W-1:0] code_d;
  logic            accept;

  always_comb begin
    accept = wr_en && !run_stop && (wr_code <= TM_LAST_LEGAL);
    code_d = accept ? wr_code : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= TM_OFF;
    else        code_q <= code_d;
  end

  assign code        = code_q;
  assign preemph_off = (code_q == TM_JSTATE) || (code_q == TM_KSTATE);

  // R6: stored code is never a reserved value
  assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code <= TM_LAST_LEGAL);

  // R7: no change of test mode while the controller runs
  assert_frozen_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_stop |=> $stable(code));
endmodule

// File: rtl/port_owner_ctl.sv
module port_owner_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_flag,
  input  logic wr_en,
  input  logic wr_val,
  output logic owner
);
  logic cfg_rise;
  logic owner_q;
  logic owner_d;

  port_edge_det cfg_edge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_in(cfg_flag),
    .rise  (cfg_rise)
  );

  always_comb begin
    if (!cfg_flag)     owner_d = 1'b1;
    else if (cfg_rise) owner_d = 1'b0;
    else if (wr_en)    owner_d = wr_val;
    else               owner_d = owner_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= 1'b1;
    else        owner_q <= owner_d;
  end

  assign owner = owner_q;

  // R9: companion holds the port after a cycle with the flag low
  assert_owner_low_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_flag |=> owner);

  // R10: a rising flag takes the port back, beating any write
  assert_owner_cfg_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_flag) |=> !owner);
endmodule

// File: rtl/usb_port_ctl_reg.sv
module usb_port_ctl_reg
  import usbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              conn_sts,
  input  logic              cfg_flag,
  input  logic              run_stop,
  output logic              pme_set,
  output logic [TM_W-1:0]   test_mode,
  output logic              preemph_off,
  output logic              companion_own
);
  logic wake_en_q;
  logic wake_en_d;
  logic conn_rise;
  logic owner;
  logic unused_wdata;

  assign unused_wdata = ^{reg_wdata[REG_W-1:WAKE_BIT+1], reg_wdata[TM_LSB-1:OWNER_BIT+1],
                          reg_wdata[OWNER_BIT-1:0]};

  always_comb wake_en_d = reg_wr ? reg_wdata[WAKE_BIT] : wake_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_en_q <= 1'b0;
    else        wake_en_q <= wake_en_d;
  end

  port_edge_det conn_edge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_in(conn_sts),
    .rise  (conn_rise)
  );

  assign pme_set = wake_en_q & conn_rise;

  port_test_sel test_sel_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .wr_code    (reg_wdata[TM_MSB:TM_LSB]),
    .run_stop   (run_stop),
    .code       (test_mode),
    .preemph_off(preemph_off)
  );

  port_owner_ctl owner_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_flag(cfg_flag),
    .wr_en   (reg_wr),
    .wr_val  (reg_wdata[OWNER_BIT]),
    .owner   (owner)
  );

  assign companion_own = owner;

  always_comb begin
    reg_rdata                 = '0;
    reg_rdata[WAKE_BIT]       = wake_en_q;
    reg_rdata[TM_MSB:TM_LSB]  = test_mode;
    reg_rdata[OWNER_BIT]      = owner;
    reg_rdata[POWER_BIT]      = 1'b1;
  end

  // R2: wake request never lasts more than one clock
  assert_pme_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pme_set |=> !pme_set);

  // R3: no wake request without the enable
  assert_pme_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pme_set |-> reg_rdata[WAKE_BIT]);

  // R5: pre-emphasis forced off only in J/K tests
  assert_preemph_jk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    preemph_off |-> (test_mode == TM_JSTATE || test_mode == TM_KSTATE));

  // R8: fixed bits
  assert_fixed_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[POWER_BIT] && reg_rdata[TM_LSB-1:OWNER_BIT+1] == '0);
endmodule

// File: tb/usb_port_ctl_reg_tb.sv
`timescale 1ns/1ps
module usb_port_ctl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        conn_sts = 1'b0;
  logic        cfg_flag = 1'b0;
  logic        run_stop = 1'b0;
  logic        pme_set;
  logic [3:0]  test_mode;
  logic        preemph_off;
  logic        companion_own;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  usb_port_ctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .conn_sts(conn_sts), .cfg_flag(cfg_flag),
    .run_stop(run_stop), .pme_set(pme_set), .test_mode(test_mode),
    .preemph_off(preemph_off), .companion_own(companion_own)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one-clock write, returns at the following negedge
  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rdata", reg_rdata, 32'h0000_3000);
    chk("R1 pme", {31'b0, pme_set}, 0);
    chk("R1 test_mode", {28'b0, test_mode}, 0);
    chk("R1 preemph", {31'b0, preemph_off}, 0);
    chk("R1 owner", {31'b0, companion_own}, 1);
  endtask

  task automatic t_wake;
    wr(32'h0010_2000);
    chk("R2 wake readback", {31'b0, reg_rdata[20]}, 1);
    conn_sts = 1'b1; #1;
    chk("R2 pulse high", {31'b0, pme_set}, 1);
    @(negedge clk);
    chk("R2 pulse one clock", {31'b0, pme_set}, 0);
    @(negedge clk);
    chk("R3 steady connect", {31'b0, pme_set}, 0);
    conn_sts = 1'b0; #1;
    chk("R3 falling connect", {31'b0, pme_set}, 0);
    wr(32'h0000_2000);
    chk("R2 wake cleared", {31'b0, reg_rdata[20]}, 0);
    conn_sts = 1'b1; #1;
    chk("R3 disabled", {31'b0, pme_set}, 0);
    @(negedge clk);
    conn_sts = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_test;
    for (int c = 1; c <= 5; c++) begin
      wr({12'b0, c[3:0], 16'h2000});
      chk("R4 test_mode", {28'b0, test_mode}, c);
      chk("R4 field", {28'b0, reg_rdata[19:16]}, c);
      chk("R5 preemph", {31'b0, preemph_off}, (c == 1 || c == 2) ? 1 : 0);
    end
    wr(32'h0003_2000);
    wr(32'h0006_2000);
    chk("R6 code 6 ignored", {28'b0, test_mode}, 3);
    wr(32'h000F_2000);
    chk("R6 code 15 ignored", {28'b0, reg_rdata[19:16]}, 3);
    run_stop = 1'b1;
    wr(32'h0001_2000);
    chk("R7 running write ignored", {28'b0, test_mode}, 3);
    chk("R7 preemph unchanged", {31'b0, preemph_off}, 0);
    run_stop = 1'b0;
    wr(32'h0000_2000);
    chk("R4 back to normal", {28'b0, test_mode}, 0);
  endtask

  task automatic t_owner;
    wr(32'h0000_0000);
    chk("R9 write ignored cfg low", {31'b0, companion_own}, 1);
    @(negedge clk);
    cfg_flag = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h0000_2000;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R10 rise beats write", {31'b0, reg_rdata[13]}, 0);
    wr(32'h0000_2000);
    chk("R9 write 1", {31'b0, companion_own}, 1);
    wr(32'h0000_0000);
    chk("R9 write 0", {31'b0, companion_own}, 0);
    cfg_flag = 1'b0;
    @(negedge clk);
    chk("R9 cfg low forces 1", {31'b0, reg_rdata[13]}, 1);
  endtask

  task automatic t_fixed;
    cfg_flag = 1'b1;
    @(negedge clk);
    run_stop = 1'b1;
    wr(32'hFFFF_FFFF);
    chk("R8 upper", {21'b0, reg_rdata[31:21]}, 0);
    chk("R8 reserved 15:14", {30'b0, reg_rdata[15:14]}, 0);
    chk("R8 power", {31'b0, reg_rdata[12]}, 1);
    chk("R8 low", {20'b0, reg_rdata[11:0]}, 0);
    run_stop = 1'b0;
    cfg_flag = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wake();
    t_test();
    t_owner();
    t_fixed();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule